// File: doc/BRIEF.md
# Transfer Unit Packer with Blanking Control

This block sits in the link clock domain of a display transmitter (target 135 MHz). It accepts video as pairs of 24-bit pixels, one pixel per lane, slices every pixel into three 8-bit symbols and places two symbol slots per lane on every clock. Active line data is carried in transfer units of `TU_LEN` slots (64 by default). Each unit opens with its data symbols and closes with a padding region. The number of data symbols per unit comes from an integer count plus a fractional part. A fractional accumulator adds one extra data symbol whenever it carries, so unit payloads never differ by more than one symbol.

A line opens with a blank-end code in the cycle that accepts its first pixel pair. The first transfer unit starts on the next clock. The line closes with a blank-start code in the slot right after its last data symbol. Vertical-blank lines arrive as dummy pixel lines and are consumed at the normal cadence. For these lines the blank-end code, the data and the padding become idle codes. Only the blank-start code remains, in the slot where it would have fallen. If a data slot is due and no pixel pair is available, the unit stalls and an underflow flag is raised for that cycle.

Top module: `tu_packer`

## Requirements
- R1: Units are `TU_LEN` slots long per lane. Two slots are emitted per clock (slot 0 of a cycle precedes slot 1). The first unit of a line begins on the cycle after the blank-end cycle, and units follow back to back until the line ends.
- R2: The data count of a unit is `data_int` plus the carry of an accumulator. The accumulator is cleared at line start and adds `frac` (FRAC_W bits) once per unit, including the first unit.
- R3: A unit's slots after its data are padding: the first padding slot is fill-start, slot `TU_LEN-1` is fill-end, and the rest are fill. Fill-end wins when only one padding slot exists, and there is no padding when the count equals `TU_LEN`.
- R4: A pixel yields symbols in the order bits [23:16], [15:8], [7:0]. Lane A takes `pix_a` and lane B takes `pix_b`. Symbols run contiguously across cycles and units, and every pair of the line is consumed exactly once.
- R5: In the idle state, a pair with `pix_valid` and `pix_sol` starts a line. That cycle outputs idle in slot 0 and blank-end in slot 1, and the next cycle's slot 0 is data.
- R6: Blank-start occupies the slot right after the last data symbol of the line. A remaining slot in that cycle is idle, and outputs stay idle until the next line starts.
- R7: When `pix_vblank` is high on the starting pair, the line keeps its timing, but blank-end, data and padding are all emitted as idle; blank-start still appears.
- R8: When a data slot is due, the buffer is short and `pix_valid` is low, `underflow` is 1, all four outputs are idle, `pix_ready` is 0 and the unit position is held.
- R9: In the idle state, pairs without `pix_sol` are accepted (`pix_ready` high) and discarded, and the outputs stay idle.
- R10: Outputs are 9 bits, {control flag, byte}. Data has flag 0. Codes with flag 1: idle 00h, blank-start B1h, blank-end B2h, fill-start F1h, fill-end F2h, fill F0h. Lane B carries the same control codes as lane A.
- R11: After reset all outputs are idle, `underflow` is 0 and `pix_ready` is 0 while `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_int | input | $clog2(TU_LEN)+1 | Integer data symbols per unit (1 to TU_LEN-1) |
| frac | input | FRAC_W | Fractional data symbols per unit, in 1/2^FRAC_W |
| line_pairs | input | NPAIR_W | Pixel pairs per line (at least 1) |
| pix_valid | input | 1 | Pixel pair available |
| pix_sol | input | 1 | Pair is the first of a line |
| pix_vblank | input | 1 | Line is a vertical-blank dummy line (sampled with the first pair) |
| pix_a | input | 24 | Lane A pixel |
| pix_b | input | 24 | Lane B pixel |
| pix_ready | output | 1 | Pair accepted this cycle |
| out_a0 | output | 9 | Lane A, slot 0 |
| out_a1 | output | 9 | Lane A, slot 1 |
| out_b0 | output | 9 | Lane B, slot 0 |
| out_b1 | output | 9 | Lane B, slot 1 |
| underflow | output | 1 | Data slot stalled for lack of input |

## Verification
The embedded assertions watch, on every clock, the local rules of the slot stream. A stall shows only idle codes and takes no pair. The two lanes agree on control flags. Data in slot 1 implies data in slot 0. Blank-end is followed by data, and blank-start is followed by silence. The unit data count and buffer fill also stay in range. The exact payload per unit, the positions of the padding markers, the symbol order from each pixel and the blank-start placement in dummy lines are long-range properties. Only the bench's sweep can show them, by comparing every cycle of many lines with a slot stream rebuilt from the integer count, the fraction and the line length.

// File: rtl/tu_packer.sv
module tu_packer #(
  parameter int TU_LEN = 64,
  parameter int FRAC_W = 8,
  parameter int NPAIR_W = 12,
  parameter logic [7:0] C_IDLE = 8'h00,
  parameter logic [7:0] C_BS   = 8'hB1,
  parameter logic [7:0] C_BE   = 8'hB2,
  parameter logic [7:0] C_FS   = 8'hF1,
  parameter logic [7:0] C_FE   = 8'hF2,
  parameter logic [7:0] C_FILL = 8'hF0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(TU_LEN):0]   data_int,
  input  logic [FRAC_W-1:0]         frac,
  input  logic [NPAIR_W-1:0]        line_pairs,
  input  logic                      pix_valid,
  input  logic                      pix_sol,
  input  logic                      pix_vblank,
  input  logic [23:0]               pix_a,
  input  logic [23:0]               pix_b,
  output logic                      pix_ready,
  output logic [8:0]                out_a0,
  output logic [8:0]                out_a1,
  output logic [8:0]                out_b0,
  output logic [8:0]                out_b1,
  output logic                      underflow
);

  localparam int POS_W  = $clog2(TU_LEN / 2);
  localparam int SLOT_W = $clog2(TU_LEN) + 1;
  localparam int LEFT_W = NPAIR_W + 2;
  localparam logic [8:0] IDLE9 = {1'b1, C_IDLE};
  localparam logic [8:0] BS9   = {1'b1, C_BS};
  localparam logic [8:0] BE9   = {1'b1, C_BE};

  typedef enum logic [1:0] {S_IDLE, S_LINE, S_BS} st_t;

  st_t               st;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] dcnt;
  logic [FRAC_W-1:0] acc;
  logic [LEFT_W-1:0] left;
  logic              vb;
  logic [2:0]        cnt;
  logic [31:0]       sbuf [2];
  logic [31:0]       comb [2];
  logic [23:0]       lpix [2];

  function automatic logic [8:0] pad(input logic [SLOT_W-1:0] s, input logic [SLOT_W-1:0] d);
    if (s == SLOT_W'(TU_LEN - 1)) return {1'b1, C_FE};
    else if (s == d)              return {1'b1, C_FS};
    else                          return {1'b1, C_FILL};
  endfunction

  logic              in_line, start, dat0, dat1, need, load, hold;
  logic [1:0]        k;
  logic [SLOT_W-1:0] s0, s1, d_next;
  logic [FRAC_W:0]   acc_sum;
  logic [8:0]        c0, c1;

  assign in_line = (st == S_LINE);
  assign start   = (st == S_IDLE) && pix_valid && pix_sol;
  assign s0      = {1'b0, pos, 1'b0};
  assign s1      = {1'b0, pos, 1'b1};
  assign dat0    = in_line && (s0 < dcnt) && (left != '0);
  assign dat1    = in_line && (s1 < dcnt) && (left > LEFT_W'(1));
  assign k       = {1'b0, dat0} + {1'b0, dat1};
  assign need    = {1'b0, k} > cnt;
  assign hold    = need && !pix_valid;
  assign load    = pix_valid && ((st == S_IDLE) || need);
  assign acc_sum = {1'b0, (st == S_IDLE) ? '0 : acc} + {1'b0, frac};
  assign d_next  = data_int + SLOT_W'(acc_sum[FRAC_W]);

  assign underflow = hold;
  assign pix_ready = load;
  assign lpix[0]   = pix_a;
  assign lpix[1]   = pix_b;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign comb[l] = sbuf[l] | (load ? ({lpix[l], 8'h00} >> {cnt, 3'b000}) : 32'h0);
  end

  always_comb begin
    c0 = IDLE9;
    c1 = IDLE9;
    case (st)
      S_IDLE: if (start && !pix_vblank) c1 = BE9;
      S_BS:   c0 = BS9;
      default: if (!hold) begin
        if (!dat0 && !vb) c0 = pad(s0, dcnt);
        if (!dat1) begin
          if (dat0 && left == LEFT_W'(1)) c1 = BS9;
          else if (!vb)                   c1 = pad(s1, dcnt);
        end
      end
    endcase
  end

  logic use0, use1;
  assign use0   = dat0 && !hold && !vb;
  assign use1   = dat1 && !hold && !vb;
  assign out_a0 = use0 ? {1'b0, comb[0][31:24]} : c0;
  assign out_a1 = use1 ? {1'b0, comb[0][23:16]} : c1;
  assign out_b0 = use0 ? {1'b0, comb[1][31:24]} : c0;
  assign out_b1 = use1 ? {1'b0, comb[1][23:16]} : c1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pos  <= '0;
      dcnt <= '0;
      acc  <= '0;
      left <= '0;
      vb   <= 1'b0;
      cnt  <= '0;
      for (int l = 0; l < 2; l++) sbuf[l] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st   <= S_LINE;
          pos  <= '0;
          acc  <= acc_sum[FRAC_W-1:0];
          dcnt <= d_next;
          left <= {line_pairs, 1'b0} + LEFT_W'(line_pairs);
          vb   <= pix_vblank;
          cnt  <= 3'd3;
          for (int l = 0; l < 2; l++) sbuf[l] <= comb[l];
        end
        S_LINE: if (!hold) begin
          for (int l = 0; l < 2; l++) sbuf[l] <= comb[l] << {k, 3'b000};
          cnt  <= cnt + (load ? 3'd3 : 3'd0) - {1'b0, k};
          left <= left - LEFT_W'(k);
          pos  <= pos + 1'b1;
          if (pos == '1) begin
            acc  <= acc_sum[FRAC_W-1:0];
            dcnt <= d_next;
          end
          if (dat0 && left == LEFT_W'(k)) st <= dat1 ? S_BS : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (out_a0 == IDLE9 && out_a1 == IDLE9 && out_b0 == IDLE9 && out_b1 == IDLE9 && !pix_ready));

  assert_lane_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a0[8] == out_b0[8]) && (out_a1[8] == out_b1[8]));

  assert_slot_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_a1[8] |-> !out_a0[8]);

  assert_be_then_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a1 == BE9) |=> !out_a0[8]);

  assert_bs_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a1 == BS9) |=> (out_a0 == IDLE9));

  assert_bs_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a0 == BS9) |-> (out_a1 == IDLE9 && !pix_ready));

  assert_unit_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_line |-> (dcnt != '0 && dcnt <= SLOT_W'(TU_LEN)));

  assert_buf_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd3);

endmodule

// File: tb/tu_packer_test.sv
module tu_packer_test;
  localparam logic [8:0] IDLE9 = 9'h100, BS9 = 9'h1B1, BE9 = 9'h1B2;
  localparam logic [8:0] FS9 = 9'h1F1, FE9 = 9'h1F2, FILL9 = 9'h1F0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [6:0]  data_int = 7'd1;
  logic [7:0]  frac = '0;
  logic [11:0] line_pairs = 12'd1;
  logic        pix_valid = 1'b0, pix_sol = 1'b0, pix_vblank = 1'b0;
  logic [23:0] pix_a = '0, pix_b = '0;
  logic        pix_ready, underflow;
  logic [8:0]  out_a0, out_a1, out_b0, out_b1;

  int total = 0, bad = 0, ln = 0, cycles = 0;
  logic [35:0] expq[$];

  always #10 clk = ~clk;

  tu_packer uut (.clk, .rst_n, .data_int, .frac, .line_pairs, .pix_valid, .pix_sol,
                 .pix_vblank, .pix_a, .pix_b, .pix_ready, .out_a0, .out_a1,
                 .out_b0, .out_b1, .underflow);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s line %0d: actual=%h expected=%h", req, ln, act, exp);
    end
  endtask

  function automatic logic [23:0] pxa(int l, int i);
    return {8'(l), 8'(i), 8'(i * 5 + l * 3 + 1)};
  endfunction

  function automatic logic [23:0] pxb(int l, int i);
    return pxa(l, i) ^ 24'hA5C3E7;
  endfunction

  task automatic build(int di, int fr, int np, bit vb);
    logic [8:0] ea[$];
    logic [8:0] eb[$];
    int acc = 0, j = 0, tot = 3 * np, d, sum;
    bit done = 0;
    ea.push_back(IDLE9); eb.push_back(IDLE9);
    ea.push_back(vb ? IDLE9 : BE9); eb.push_back(vb ? IDLE9 : BE9);
    while (!done) begin
      sum = acc + fr; acc = sum % 256; d = di + sum / 256;
      for (int s = 0; s < 64 && !done; s++) begin
        if (j == tot) begin
          ea.push_back(BS9); eb.push_back(BS9); done = 1;
        end else if (s < d) begin
          if (vb) begin ea.push_back(IDLE9); eb.push_back(IDLE9); end
          else begin
            ea.push_back({1'b0, 8'(pxa(ln, j / 3) >> (16 - 8 * (j % 3)))});
            eb.push_back({1'b0, 8'(pxb(ln, j / 3) >> (16 - 8 * (j % 3)))});
          end
          j++;
        end else begin
          logic [8:0] pc;
          pc = (s == 63) ? FE9 : (s == d) ? FS9 : FILL9;
          if (vb) pc = IDLE9;
          ea.push_back(pc); eb.push_back(pc);
        end
      end
    end
    if (ea.size() % 2 == 1) begin ea.push_back(IDLE9); eb.push_back(IDLE9); end
    for (int c = 0; c < ea.size(); c += 2)
      expq.push_back({ea[c], ea[c+1], eb[c], eb[c+1]});
  endtask

  task automatic run_line(int di, int fr, int np, bit vb, int gap_at, int gap_len, bit drop);
    int i = 0, cyc = 0, uf = 0;
    logic [35:0] got, exp;
    string req;
    ln++;
    req = vb ? "R7 R6" : "R1 R2 R3 R4 R5 R6 R10";
    data_int = 7'(di); frac = 8'(fr); line_pairs = 12'(np);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk); pix_valid = 0; #5;
      got = {out_a0, out_a1, out_b0, out_b1};
      check(got == {4{IDLE9}} && !underflow, "R6 idle between lines", got, {4{IDLE9}});
    end
    if (drop) begin
      @(negedge clk);
      pix_valid = 1; pix_sol = 0; pix_a = 24'hDEAD01; pix_b = 24'hBEEF02; #5;
      got = {out_a0, out_a1, out_b0, out_b1};
      check(pix_ready && got == {4{IDLE9}}, "R9 stray pair dropped", {pix_ready, got[34:0]}, {1'b1, IDLE9, IDLE9, IDLE9, 8'h00});
    end
    build(di, fr, np, vb);
    while (expq.size() > 0) begin
      @(negedge clk);
      pix_valid = (i < np) && !(cyc >= gap_at && cyc < gap_at + gap_len);
      pix_sol = (i == 0); pix_vblank = vb;
      pix_a = pxa(ln, i); pix_b = pxb(ln, i);
      #5;
      got = {out_a0, out_a1, out_b0, out_b1};
      if (underflow) begin
        uf++;
        check(got == {4{IDLE9}} && !pix_ready, "R8 stall outputs idle", got, {4{IDLE9}});
      end else begin
        exp = expq.pop_front();
        check(got === exp, req, got, exp);
      end
      if (pix_ready && pix_valid) i++;
      cyc++;
    end
    @(negedge clk); pix_valid = 0; pix_sol = 0;
    check(i == np, "R4 pairs consumed", 36'(i), 36'(np));
    if (gap_len > 0) check(uf > 0, "R8 underflow raised", 36'(uf), 36'(1));
  endtask

  initial begin
    int dis[4] = '{1, 7, 32, 63};
    int frs[4] = '{0, 85, 200, 255};
    int nps[4] = '{1, 2, 23, 32};
    repeat (3) @(negedge clk);
    #5;
    check(out_a0 == IDLE9 && out_a1 == IDLE9 && out_b0 == IDLE9 && out_b1 == IDLE9
          && !underflow && !pix_ready, "R11 reset state",
          {out_a0, out_a1, out_b0, out_b1}, {4{IDLE9}});
    @(negedge clk); rst_n = 1;
    run_line(32, 0, 23, 0, 0, 0, 1);
    run_line(32, 0, 23, 0, 3, 4, 0);
    run_line(63, 0, 21, 0, 0, 0, 0);
    run_line(63, 0, 21, 1, 2, 3, 0);
    foreach (dis[a]) foreach (frs[b]) foreach (nps[c])
      for (int v = 0; v < 2; v++) run_line(dis[a], frs[b], nps[c], v[0], 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule